// File: doc/BRIEF.md
# Transmit Descriptor Queue Walker

This block walks a ring of transmit descriptors held in shared memory and turns them into a byte stream for a transmit MAC. Each descriptor occupies two 32-bit words at an 8-byte-aligned address. The word at offset 0 is the byte address of a data buffer, and the word at offset 4 is a control/status word. The walker reads each descriptor, fetches the buffer's bytes word by word, and presents them one byte at a time on a valid/ready stream. Buffers are chained into one frame until a descriptor carries the last-buffer flag.

When a frame has been handed over, the walker waits for the MAC's completion status. It then writes a status word back over the control word of the frame's first descriptor and moves on to the next frame. A frame may request automatic CRC, in which case the walker pads short frames with zero bytes and tells the MAC to append the checksum. Software loads the ring base while the walker is idle and then pulses a start input. The walker keeps running until it meets a descriptor that is still owned by software.

Control word fields:
- Bits 10:0: buffer length in bytes.
- Bit 15: last buffer of the frame.
- Bit 16: no CRC.
- Bits 29:27: error code.
- Bit 30: wrap.
- Bit 31: used.

Top module: `txq_walker`

## Requirements
- R1: For each descriptor at pointer P, the control word is read from P+4 and the buffer address from P. Length bytes are then streamed starting at that byte address. The byte at an address whose low two bits are k is bits 8k+7:8k of the word read from that address with its low two bits cleared.
- R2: A frame is made of consecutive descriptors up to and including the one with bit 15 set. Descriptors of length 0 add no bytes. `st_last` is high on exactly the final byte of the frame.
- R3: If bit 16 of the frame's first control word is 0, the frame is padded with zero bytes to 60 data bytes and `st_crc` is high with `st_last`. If bit 16 is 1, there is no padding and `st_crc` stays low.
- R4: If bit 31 is set in the control word read at the start of a frame, the walker stops. `tx_active` falls, `used_stop` rises and stays high until the next start, and no write is issued.
- R5: After the last byte is accepted and `mac_stat_valid` is seen, the walker writes to first-descriptor+4. The written word is the first control word with bit 31 set and bits 29:27 replaced by `mac_stat[2:0]`.
- R6: After a descriptor with bit 30 set, the next descriptor is read at the ring base. After 1024 consecutive descriptors without bit 30, the pointer also returns to the base.
- R7: If a frame reaches a 129th descriptor, the frame is aborted. Descriptors are skipped up to the one with bit 15 set, and the first control word is written back with bits 31 and 29 set, without padding and without waiting for MAC status.
- R8: A `qptr_we` pulse while idle loads both the ring base and the current pointer. A `qptr_we` pulse while `tx_active` is high has no effect.
- R9: `mem_req` is low while idle. A request keeps `mem_addr` and `mem_we` stable until `mem_gnt`. Addresses are word aligned. Only one read is outstanding at a time.
- R10: A stream byte that is not accepted keeps `st_valid`, `st_data`, `st_last` and `st_crc` unchanged.
- R11: A frame that produces no bytes (all lengths 0, bit 16 set) emits nothing on the stream. Its first control word is written back with bit 31 set and bits 29:27 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qptr_we | input | 1 | Load ring base (idle only) |
| qptr_val | input | 32 | Ring base byte address, 8-byte aligned |
| tx_go | input | 1 | Start walking (idle only) |
| tx_active | output | 1 | Walker running |
| used_stop | output | 1 | Stopped on a software-owned descriptor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| st_valid | output | 1 | Stream byte valid |
| st_ready | input | 1 | MAC accepts byte |
| st_data | output | 8 | Stream byte |
| st_last | output | 1 | Final byte of frame |
| st_crc | output | 1 | MAC must append CRC (with last) |
| mac_stat_valid | input | 1 | MAC completion status strobe |
| mac_stat | input | 3 | MAC error code for the frame |

## Verification
The checks assume three things about the block's inputs:
- The memory returns read data only after granting a request, and never grants a request that is not asserted.
- The ring base is 8-byte aligned.
- `mac_stat_valid` arrives only after the final byte of a non-aborted frame.

The stimulus respects this. The memory model answers exactly one cycle after each grant and withholds grant in a fixed pattern. The MAC model strobes status a few cycles after it accepts a byte marked last. Every ring base used is a multiple of eight. The stream consumer stalls periodically, so that byte holding under backpressure is exercised across word and buffer boundaries.

// File: rtl/txq_walker.sv
module txq_walker #(
  parameter int LEN_W     = 11,
  parameter int MAX_BUFS  = 128,
  parameter int RING_DESC = 1024,
  parameter int MIN_FRAME = 64,
  parameter int CRC_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        qptr_we,
  input  logic [31:0] qptr_val,
  input  logic        tx_go,
  output logic        tx_active,
  output logic        used_stop,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        st_valid,
  input  logic        st_ready,
  output logic [7:0]  st_data,
  output logic        st_last,
  output logic        st_crc,
  input  logic        mac_stat_valid,
  input  logic [2:0]  mac_stat
);
  localparam int PAD_TO = MIN_FRAME - CRC_BYTES;
  localparam int BC_W   = $clog2(MAX_BUFS + 1);
  localparam int RING_W = $clog2(RING_DESC);
  localparam int FB_W   = $clog2(MAX_BUFS * (2 ** LEN_W)) + 1;
  localparam int B_LAST = 15;
  localparam int B_NOCRC = 16;
  localparam int B_WRAP = 30;
  localparam int B_USED = 31;

  typedef enum logic [3:0] {
    S_IDLE, S_RCTL, S_RADR, S_RDAT, S_SEND, S_NXT, S_PAD, S_FLUSH, S_MAC, S_WB
  } st_t;

  st_t               state, fin_st;
  logic [31:0]       base, cur, first_ptr, ba, word, nxt_ptr;
  logic [RING_W-1:0] ring_cnt, nxt_ring;
  logic [BC_W-1:0]   buf_cnt;
  logic [LEN_W-1:0]  cur_len;
  logic [FB_W-1:0]   frame_bytes;
  logic [26:0]       first_lo;
  logic              first_wrap, cur_last, cur_wrap, crc_on, abort, rd_out;
  logic              pend_v;
  logic [7:0]        pend_d, byte_sel, nb;
  logic [2:0]        err;
  logic              rd_state, rdone, wrap_sel, roll, need_pad, emit_go;

  assign tx_active = (state != S_IDLE);
  assign rd_state  = (state == S_RCTL) || (state == S_RADR) || (state == S_RDAT);
  assign mem_req   = (rd_state && !rd_out) || (state == S_WB);
  assign mem_we    = (state == S_WB);
  assign mem_wdata = {1'b1, first_wrap, err, first_lo};
  assign rdone     = rd_state && rd_out && mem_rvalid;

  always_comb begin
    unique case (state)
      S_RCTL:  mem_addr = cur + 32'd4;
      S_RADR:  mem_addr = cur;
      S_RDAT:  mem_addr = {ba[31:2], 2'b00};
      S_WB:    mem_addr = first_ptr + 32'd4;
      default: mem_addr = 32'd0;
    endcase
  end

  assign wrap_sel = (state == S_RCTL) ? mem_rdata[B_WRAP] : cur_wrap;
  assign roll     = wrap_sel || (ring_cnt == RING_W'(RING_DESC - 1));
  assign nxt_ptr  = roll ? base : cur + 32'd8;
  assign nxt_ring = roll ? '0 : ring_cnt + 1'b1;

  always_comb begin
    unique case (ba[1:0])
      2'd0: byte_sel = word[7:0];
      2'd1: byte_sel = word[15:8];
      2'd2: byte_sel = word[23:16];
      default: byte_sel = word[31:24];
    endcase
  end

  assign nb       = (state == S_PAD) ? 8'h00 : byte_sel;
  assign emit_go  = ((state == S_SEND) || (state == S_PAD)) && (!pend_v || st_ready);
  assign need_pad = crc_on && (frame_bytes < FB_W'(PAD_TO));
  assign fin_st   = need_pad ? S_PAD : (pend_v ? S_FLUSH : S_WB);

  assign st_valid = pend_v && ((state == S_SEND) || (state == S_PAD) || (state == S_FLUSH));
  assign st_data  = pend_d;
  assign st_last  = (state == S_FLUSH);
  assign st_crc   = st_last && crc_on && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      base        <= '0;
      cur         <= '0;
      first_ptr   <= '0;
      ba          <= '0;
      word        <= '0;
      ring_cnt    <= '0;
      buf_cnt     <= '0;
      cur_len     <= '0;
      frame_bytes <= '0;
      first_lo    <= '0;
      first_wrap  <= 1'b0;
      cur_last    <= 1'b0;
      cur_wrap    <= 1'b0;
      crc_on      <= 1'b0;
      abort       <= 1'b0;
      rd_out      <= 1'b0;
      pend_v      <= 1'b0;
      pend_d      <= '0;
      err         <= '0;
      used_stop   <= 1'b0;
    end else begin
      if (rd_state && mem_req && mem_gnt) rd_out <= 1'b1;
      if (rdone) rd_out <= 1'b0;

      if (emit_go) begin
        pend_v      <= 1'b1;
        pend_d      <= nb;
        frame_bytes <= frame_bytes + 1'b1;
      end

      unique case (state)
        S_IDLE: begin
          if (qptr_we) begin
            base     <= qptr_val;
            cur      <= qptr_val;
            ring_cnt <= '0;
          end
          if (tx_go) begin
            state     <= S_RCTL;
            used_stop <= 1'b0;
            buf_cnt   <= '0;
            abort     <= 1'b0;
          end
        end
        S_RCTL: if (rdone) begin
          if (buf_cnt == '0 && mem_rdata[B_USED]) begin
            state     <= S_IDLE;
            used_stop <= 1'b1;
          end else if (abort || buf_cnt == BC_W'(MAX_BUFS)) begin
            abort    <= 1'b1;
            err      <= 3'b100;
            cur      <= nxt_ptr;
            ring_cnt <= nxt_ring;
            if (mem_rdata[B_LAST]) state <= pend_v ? S_FLUSH : S_WB;
          end else begin
            if (buf_cnt == '0) begin
              first_ptr   <= cur;
              first_lo    <= mem_rdata[26:0];
              first_wrap  <= mem_rdata[B_WRAP];
              crc_on      <= !mem_rdata[B_NOCRC];
              err         <= '0;
              frame_bytes <= '0;
            end
            cur_len  <= mem_rdata[LEN_W-1:0];
            cur_last <= mem_rdata[B_LAST];
            cur_wrap <= mem_rdata[B_WRAP];
            state    <= S_RADR;
          end
        end
        S_RADR: if (rdone) begin
          ba    <= mem_rdata;
          state <= (cur_len == '0) ? S_NXT : S_RDAT;
        end
        S_RDAT: if (rdone) begin
          word  <= mem_rdata;
          state <= S_SEND;
        end
        S_SEND: if (emit_go) begin
          ba      <= ba + 32'd1;
          cur_len <= cur_len - 1'b1;
          if (cur_len == LEN_W'(1))  state <= S_NXT;
          else if (ba[1:0] == 2'd3)  state <= S_RDAT;
        end
        S_NXT: begin
          cur      <= nxt_ptr;
          ring_cnt <= nxt_ring;
          buf_cnt  <= buf_cnt + 1'b1;
          state    <= cur_last ? fin_st : S_RCTL;
        end
        S_PAD: if (emit_go && frame_bytes >= FB_W'(PAD_TO - 1)) state <= S_FLUSH;
        S_FLUSH: if (st_ready) begin
          pend_v <= 1'b0;
          state  <= abort ? S_WB : S_MAC;
        end
        S_MAC: if (mac_stat_valid) begin
          err   <= mac_stat;
          state <= S_WB;
        end
        S_WB: if (mem_gnt) begin
          state   <= S_RCTL;
          buf_cnt <= '0;
          abort   <= 1'b0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txq_walker_chk.sv
module txq_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_active,
  input logic        used_stop,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_gnt,
  input logic        st_valid,
  input logic        st_ready,
  input logic [7:0]  st_data,
  input logic        st_last,
  input logic        st_crc
);
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r9_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> !mem_req && !st_valid);

  a_r10_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_last) && $stable(st_crc));

  a_r3_crc_with_last: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_crc |-> st_last);

  a_r5_wb_used_set: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[31] && mem_addr[2:0] == 3'b100);

  a_r4_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    used_stop |-> !tx_active);
endmodule

bind txq_walker txq_walker_chk i_chk (.*);

// File: tb/test_txq_walker.sv
`timescale 1ns/1ps
module test_txq_walker;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        qptr_we = 1'b0, tx_go = 1'b0;
  logic [31:0] qptr_val = '0;
  logic        tx_active, used_stop, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        st_valid, st_ready = 1'b0, st_last, st_crc;
  logic [7:0]  st_data;
  logic        mac_stat_valid = 1'b0;
  logic [2:0]  mac_stat = '0;

  always #4 clk = ~clk;

  txq_walker i_txq_walker (.*);

  int checks = 0, failures = 0;
  logic [31:0] mem [int unsigned];
  logic [9:0]  q_byte [$];
  logic [9:0]  fq [$];
  logic [63:0] q_wr [$];
  logic [2:0]  mac_q [$];
  logic [31:0] last_rd = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)};
  endfunction

  task automatic add_data(input logic [31:0] a, input int n);
    for (int i = 0; i < n; i++) fq.push_back({2'b00, pat(a + i)});
  endtask

  task automatic close_frame(input bit crc, input logic [2:0] stat);
    if (crc) while (fq.size() < 60) fq.push_back(10'h000);
    fq[fq.size() - 1] = {1'b1, crc, fq[fq.size() - 1][7:0]};
    foreach (fq[i]) q_byte.push_back(fq[i]);
    fq.delete();
    mac_q.push_back(stat);
  endtask

  task automatic pulse_ptr(input logic [31:0] v);
    qptr_val = v; qptr_we = 1'b1;
    @(negedge clk); qptr_we = 1'b0;
  endtask

  task automatic run_until_stop();
    tx_go = 1'b1;
    @(negedge clk); tx_go = 1'b0;
    @(negedge clk);
    while (!used_stop) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  // memory, MAC and stream models plus scoreboard monitor
  initial begin
    int cyc = 0, mac_cd = 0;
    bit rd_pend = 1'b0;
    logic [31:0] rd_addr = '0;
    logic [2:0]  cur_stat = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 190000) begin
        chk(1'b0, "watchdog", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
      mem_rvalid = rd_pend;
      if (rd_pend) mem_rdata = rd_word(rd_addr);
      rd_pend = 1'b0;
      mem_gnt = mem_req && (cyc % 3 != 1);
      if (mem_gnt && !mem_we) begin
        rd_pend = 1'b1; rd_addr = mem_addr; last_rd = mem_addr;
      end
      if (mem_gnt && mem_we) begin
        if (q_wr.size() == 0) chk(1'b0, "R4/R5 unexpected write", {mem_addr, mem_wdata}, 0);
        else begin
          logic [63:0] e;
          e = q_wr.pop_front();
          chk({mem_addr, mem_wdata} == e, "R5/R7/R11 write-back", {mem_addr, mem_wdata}, e);
        end
        mem[mem_addr] = mem_wdata;
      end
      mac_stat_valid = 1'b0;
      if (mac_cd == 1) begin mac_stat_valid = 1'b1; mac_stat = cur_stat; end
      if (mac_cd > 0) mac_cd--;
      st_ready = (cyc % 5 != 2);
      if (st_valid && st_ready) begin
        if (q_byte.size() == 0) chk(1'b0, "R2 unexpected byte", {st_last, st_crc, st_data}, 0);
        else begin
          logic [9:0] e;
          e = q_byte.pop_front();
          chk({st_last, st_crc, st_data} == e, "R1/R2/R3 stream byte", {st_last, st_crc, st_data}, e);
        end
        if (st_last) begin
          if (mac_q.size() == 0) chk(1'b0, "R2 unexpected last", 1, 0);
          else begin cur_stat = mac_q.pop_front(); mac_cd = 4; end
        end
      end
    end
  end

  task automatic end_checks(input string tag, input logic [31:0] stop_rd);
    chk(q_byte.size() == 0, {tag, " bytes drained"}, q_byte.size(), 0);
    chk(q_wr.size() == 0, {tag, " writes drained"}, q_wr.size(), 0);
    chk(mac_q.size() == 0, {tag, " frames closed"}, mac_q.size(), 0);
    chk(last_rd == stop_rd, {tag, " stop pointer"}, last_rd, stop_rd);
    chk(!tx_active && used_stop, "R4 stopped state", {tx_active, used_stop}, 2'b01);
  endtask

  initial begin
    logic [31:0] c;
    repeat (4) @(negedge clk);
    chk(!tx_active, "R9 reset tx_active", tx_active, 0);
    chk(!used_stop, "R4 reset used_stop", used_stop, 0);
    chk(!mem_req, "R9 reset mem_req", mem_req, 0);
    chk(!st_valid, "R10 reset st_valid", st_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Run A: R1 R2 R3 R5 R6(wrap) R4
    mem[32'h1000] = 32'h2001; mem[32'h1004] = 32'd5 | (1 << 16);
    mem[32'h1008] = 32'h6000; mem[32'h100C] = (1 << 16);
    mem[32'h1010] = 32'h3002; mem[32'h1014] = 32'd70 | (1 << 15) | (1 << 16);
    mem[32'h1018] = 32'h4003; mem[32'h101C] = 32'd10 | (1 << 15);
    mem[32'h1020] = 32'h5000; mem[32'h1024] = 32'd3 | (1 << 15) | (1 << 16) | (1 << 30);
    add_data(32'h2001, 5); add_data(32'h3002, 70); close_frame(1'b0, 3'b010);
    q_wr.push_back({32'h1004, mem[32'h1004] | 32'h8000_0000 | (32'd2 << 27)});
    add_data(32'h4003, 10); close_frame(1'b1, 3'b000);
    q_wr.push_back({32'h101C, mem[32'h101C] | 32'h8000_0000});
    add_data(32'h5000, 3); close_frame(1'b0, 3'b101);
    q_wr.push_back({32'h1024, mem[32'h1024] | 32'h8000_0000 | (32'd5 << 27)});
    pulse_ptr(32'h1000);
    run_until_stop();
    end_checks("R6 wrap", 32'h1004);

    // Run B: R7 abort, R8 ignored pointer write while active
    for (int i = 0; i < 129; i++) begin
      mem[32'h8000 + 8 * i] = '0; mem[32'h8004 + 8 * i] = (1 << 16);
    end
    mem[32'h8004 + 8 * 129] = (1 << 15) | (1 << 16);
    mem[32'h8004 + 8 * 130] = 32'h8000_0000;
    q_wr.push_back({32'h8004, 32'h8000_0000 | (32'd1 << 29) | (32'd1 << 16)});
    pulse_ptr(32'h8000);
    tx_go = 1'b1;
    @(negedge clk); tx_go = 1'b0;
    repeat (30) @(negedge clk);
    chk(tx_active, "R8 active during write", tx_active, 1);
    pulse_ptr(32'h9000);
    while (!used_stop) @(negedge clk);
    repeat (10) @(negedge clk);
    end_checks("R7/R8 abort", 32'h8004 + 8 * 130);

    // Run C: R11 empty frames, R6 rollover after 1024 descriptors
    for (int i = 0; i < 1024; i++) begin
      c = (1 << 15) | (1 << 16);
      mem[32'h10000 + 8 * i] = 32'h7000;
      mem[32'h10004 + 8 * i] = c;
      q_wr.push_back({32'h10004 + 32'(8 * i), c | 32'h8000_0000});
    end
    pulse_ptr(32'h10000);
    run_until_stop();
    end_checks("R6/R11 rollover", 32'h10004);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule